// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog built around a 12-bit down-counter that steps once per tick of a programmable prescaler. Software controls it through four word-wide registers on a simple synchronous bus: a key register for commands, a prescaler code, a reload value and a read-only status word. Three 16-bit key codes act as commands. One opens write access to the two timing registers, one starts the watchdog and one reloads ("kicks") the counter. Once started, the watchdog cannot be halted by any bus access. When the counter runs out, the block raises a one-cycle reset request and then begins a new timeout period.

Changes to the prescaler and reload registers are committed to the counting logic through a fixed-length transfer that models a move into a separate timing domain. While a transfer is in flight, a status flag is set. During that time, further writes to the same register are dropped and read-back returns the old value. Everything runs on one clock. The prescaler output is a tick enable, so the "counter clock" period is one tick of `clk` for the transfer timing.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the prescaler register reads 0, the reload register reads 0xFFF, the status register reads 0 and `rst_req` is low.
- R2: A key write of 0x5555 (bits 15:0 of the write data) opens write access to the prescaler and reload registers. A key write of any other value closes it. Writes to either register while access is closed are ignored and set no status flag.
- R3: An accepted write to the prescaler (or reload) register sets status bit 0 (or bit 1) for exactly 5 clock cycles, starting the cycle after the write. A write to the same register while its flag is set is ignored.
- R4: While its flag is set, a read of the prescaler or reload register returns the previous value. The new value is returned from the cycle the flag clears.
- R5: The prescaler register holds write-data bits 2:0 and the reload register holds bits 11:0. All other read bits are zero. Status bit 0 is the prescaler flag and bit 1 is the reload flag.
- R6: A key write of 0xCCCC starts the watchdog with the counter loaded from the reload value. `rst_req` goes high exactly (reload+1)×ratio cycles after the start write, where the prescaler code c gives ratio = 2^(2+c) for c from 0 to 6.
- R7: Prescaler codes 6 and 7 both give a ratio of 256.
- R8: A key write of 0xAAAA reloads the counter and restarts the prescaler, so the next `rst_req` comes (reload+1)×ratio cycles after that write.
- R9: `rst_req` lasts one cycle. The counter then reloads and pulses again every (reload+1)×ratio cycles. No key value written after start stops it.
- R10: Before a start key has been written, `rst_req` never rises. A reload key alone does not start the watchdog.
- R11: Registers decode on address bits 3:2: key 0x0, prescaler 0x4, reload 0x8, status 0xC. Writes to the status register are ignored, and the key register reads 0. Read data appears on `bus_rdata` the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
On every cycle, the embedded assertions check the following: the update flags rise only after a write, a committed value equals the pending one when its flag drops, a closed or busy register takes no write, the watchdog never stops once started, the reset request is a single cycle, and a reload command is never followed by a pulse. The exact timeout lengths for each prescaler code and reload value, the five-cycle flag window, the stale read-back, and the key sequences that open and close access can only be shown by the bench's scenarios. The bench sweeps every prescaler code and several reload values, measuring cycle counts against arithmetic predictions.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int KEY_W = 16;

  localparam logic [KEY_W-1:0] KEY_OPEN  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_KICK  = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_START = 16'hCCCC;

  typedef enum logic [1:0] {
    SEL_KEY  = 2'd0,
    SEL_PRE  = 2'd1,
    SEL_RLD  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/kwd_shadow_reg.sv
// Pending/committed register pair with a fixed-length transfer window.
module kwd_shadow_reg #(
  parameter int         W           = 12,
  parameter logic [W-1:0] RST_VAL   = '0,
  parameter int         SYNC_CYCLES = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value,
  output logic         busy
);
  localparam int BW = $clog2(SYNC_CYCLES + 1);

  logic [W-1:0]  pend_q;
  logic [W-1:0]  eff_q;
  logic [BW-1:0] cnt_q;

  assign busy  = (cnt_q != '0);
  assign value = eff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= RST_VAL;
      eff_q  <= RST_VAL;
      cnt_q  <= '0;
    end else if (wr_en && !busy) begin
      pend_q <= wdata;
      cnt_q  <= BW'(SYNC_CYCLES);
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == BW'(1)) eff_q <= pend_q;
    end
  end

  // R3
  busy_rise_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en));
  // R3
  busy_write_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> $stable(pend_q));
  // R4
  commit_on_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (eff_q == pend_q));
  // R4
  no_early_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q != BW'(1)) |=> $stable(eff_q));
endmodule

// File: rtl/kwd_regs.sv
// Bus decode, key commands, write protection and read mux.
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int PR_W        = 3,
  parameter int CNT_W       = 12,
  parameter int SYNC_CYCLES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [PR_W-1:0]   pr_code,
  output logic [CNT_W-1:0]  reload_val,
  output logic              start_cmd,
  output logic              kick_cmd
);
  reg_sel_e         sel;
  logic [KEY_W-1:0] key;
  logic             key_wr;
  logic             open_q;
  logic             pr_busy;
  logic             rl_busy;
  logic             pr_wr;
  logic             rl_wr;
  logic [DATA_W-1:0] rd_mux;

  assign sel       = reg_sel_e'(bus_addr[3:2]);
  assign key       = bus_wdata[KEY_W-1:0];
  assign key_wr    = bus_wr && (sel == SEL_KEY);
  assign start_cmd = key_wr && (key == KEY_START);
  assign kick_cmd  = key_wr && (key == KEY_KICK);
  assign pr_wr     = bus_wr && (sel == SEL_PRE) && open_q;
  assign rl_wr     = bus_wr && (sel == SEL_RLD) && open_q;

  always_ff @(posedge clk) begin
    if (rst)         open_q <= 1'b0;
    else if (key_wr) open_q <= (key == KEY_OPEN);
  end

  kwd_shadow_reg #(
    .W(PR_W), .RST_VAL('0), .SYNC_CYCLES(SYNC_CYCLES)
  ) u_pre (
    .clk(clk), .rst(rst), .wr_en(pr_wr), .wdata(bus_wdata[PR_W-1:0]),
    .value(pr_code), .busy(pr_busy)
  );

  kwd_shadow_reg #(
    .W(CNT_W), .RST_VAL('1), .SYNC_CYCLES(SYNC_CYCLES)
  ) u_rld (
    .clk(clk), .rst(rst), .wr_en(rl_wr), .wdata(bus_wdata[CNT_W-1:0]),
    .value(reload_val), .busy(rl_busy)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_PRE:  rd_mux = DATA_W'(pr_code);
      SEL_RLD:  rd_mux = DATA_W'(reload_val);
      SEL_STAT: rd_mux = DATA_W'({rl_busy, pr_busy});
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R2
  open_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(open_q) |-> $past(key_wr && key == KEY_OPEN));
  // R2
  closed_pre_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == SEL_PRE && !open_q && !pr_busy) |=> !pr_busy);
  // R2
  closed_rld_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == SEL_RLD && !open_q && !rl_busy) |=> !rl_busy);
endmodule

// File: rtl/kwd_prescaler.sv
// Divides the clock into a tick enable; ratio = 2^(MIN_SHIFT+code), capped.
module kwd_prescaler #(
  parameter int PR_W      = 3,
  parameter int MIN_SHIFT = 2,
  parameter int MAX_SHIFT = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            clear,
  input  logic [PR_W-1:0] code,
  output logic            tick
);
  localparam int DIV_W = MAX_SHIFT;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    if (MIN_SHIFT + int'(code) >= MAX_SHIFT)
      mask = '1;
    else
      mask = DIV_W'((64'd1 << (MIN_SHIFT + int'(code))) - 64'd1);
  end

  // >= keeps the divider bounded if the code shrinks mid-count
  assign tick = run && !clear && (div_q >= mask);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) div_q <= '0;
    else if (tick)            div_q <= '0;
    else                      div_q <= div_q + 1'b1;
  end

  // R10
  tick_only_running_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> run);
  // R8
  clear_restarts_div_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (div_q == '0));
endmodule

// File: rtl/kwd_counter.sv
// Down-counter with run latch and timeout pulse.
module kwd_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             kick,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload_val,
  output logic             running,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '1;
      running <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (start) running <= 1'b1;
      if (start || kick) begin
        cnt_q <= reload_val;
      end else if (running && tick) begin
        if (cnt_q == '0) begin
          rst_req <= 1'b1;
          cnt_q   <= reload_val;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // R9
  never_stops_chk: assert property (@(posedge clk) disable iff (rst)
    running |=> running);
  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  // R10
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !running |-> !rst_req);
  // R8
  kick_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> !rst_req);
  // R6
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(tick));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int PR_W        = 3,
  parameter int CNT_W       = 12,
  parameter int SYNC_CYCLES = 5,
  parameter int MIN_SHIFT   = 2,
  parameter int MAX_SHIFT   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  logic [PR_W-1:0]  pr_code;
  logic [CNT_W-1:0] reload_val;
  logic             start_cmd;
  logic             kick_cmd;
  logic             running;
  logic             tick;

  kwd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PR_W(PR_W),
    .CNT_W(CNT_W), .SYNC_CYCLES(SYNC_CYCLES)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pr_code(pr_code), .reload_val(reload_val),
    .start_cmd(start_cmd), .kick_cmd(kick_cmd)
  );

  kwd_prescaler #(
    .PR_W(PR_W), .MIN_SHIFT(MIN_SHIFT), .MAX_SHIFT(MAX_SHIFT)
  ) u_pre (
    .clk(clk), .rst(rst), .run(running), .clear(start_cmd || kick_cmd),
    .code(pr_code), .tick(tick)
  );

  kwd_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .start(start_cmd), .kick(kick_cmd), .tick(tick),
    .reload_val(reload_val), .running(running), .rst_req(rst_req)
  );
endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  keyed_watchdog dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    #1 bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // negedges until rst_req seen; result k means pulse followed edge k-1 after call
  task automatic wait_pulse(input int limit, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!rst_req && k < limit);
  endtask

  task automatic setup(input int code, input int rl);
    wr(4'h0, 32'h5555);
    wr(4'h4, 32'(code));
    wr(4'h8, 32'(rl));
    repeat (7) @(posedge clk);
    #1;
  endtask

  function automatic int ratio(input int code);
    return 1 << (2 + ((code > 6) ? 6 : code));
  endfunction

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    finish_test();
  end

  initial begin
    logic [31:0] d;
    int k;
    int t;
    bit seen;

    // R1 and R11 reset values and decode
    do_reset();
    rd(4'h4, d); check(d == 0, "R1 prescaler reset", d, 0);
    rd(4'h8, d); check(d == 32'hFFF, "R1 reload reset", d, 32'hFFF);
    rd(4'hC, d); check(d == 0, "R1 status reset", d, 0);
    check(rst_req == 1'b0, "R1 rst_req low", 32'(rst_req), 0);
    rd(4'h0, d); check(d == 0, "R11 key reads zero", d, 0);
    wr(4'hC, 32'h3);
    rd(4'hC, d); check(d == 0, "R11 status write ignored", d, 0);

    // R2 closed access
    wr(4'h4, 32'h5);
    rd(4'hC, d); check(d == 0, "R2 locked write no flag", d, 0);
    rd(4'h4, d); check(d == 0, "R2 locked write ignored", d, 0);

    // R3 R4 prescaler transfer window
    wr(4'h0, 32'h5555);
    wr(4'h4, 32'h5);                                   // edge N
    rd(4'hC, d); check(d == 32'h1, "R3 flag set j1", d, 1);
    wr(4'h4, 32'h3);                                   // j2, busy: dropped
    rd(4'h4, d); check(d == 0, "R4 stale read j3", d, 0);
    rd(4'hC, d); check(d == 32'h1, "R3 flag set j4", d, 1);
    rd(4'h4, d); check(d == 0, "R4 stale read j5", d, 0);
    rd(4'h4, d); check(d == 32'h5, "R4 new value j6", d, 5);
    rd(4'hC, d); check(d == 0, "R3 flag clear j7", d, 0);
    wr(4'h4, 32'h3);
    repeat (6) @(posedge clk); #1;
    rd(4'h4, d); check(d == 32'h3, "R3 write accepted after clear", d, 3);

    // R3 R5 reload flag on bit 1, field width
    wr(4'h8, 32'hFFFF_F123);
    rd(4'hC, d); check(d == 32'h2, "R5 reload flag bit1", d, 2);
    repeat (6) @(posedge clk); #1;
    rd(4'h8, d); check(d == 32'h123, "R5 reload field width", d, 32'h123);
    wr(4'h4, 32'hFFFF_FFFE);
    repeat (6) @(posedge clk); #1;
    rd(4'h4, d); check(d == 32'h6, "R5 prescaler field width", d, 6);

    // R2 relock by other keys
    wr(4'h0, 32'h1234);
    wr(4'h8, 32'h55);
    rd(4'hC, d); check(d == 0, "R2 relock no flag", d, 0);
    wr(4'h0, 32'h5555);
    wr(4'h0, 32'hAAAA);
    wr(4'h8, 32'h66);
    repeat (6) @(posedge clk); #1;
    rd(4'h8, d); check(d == 32'h123, "R2 kick key relocks", d, 32'h123);

    // R10 no pulse before start, kick does not start
    do_reset();
    setup(0, 2);
    wr(4'h0, 32'hAAAA);
    seen = 0;
    repeat (100) begin @(negedge clk); if (rst_req) seen = 1; end
    check(!seen, "R10 no pulse before start", 32'(seen), 0);

    // R6 R7 sweep of all codes
    for (int code = 0; code < 8; code++) begin
      for (int rl = 0; rl < 3; rl += 2) begin
        do_reset();
        setup(code, rl);
        wr(4'h0, 32'hCCCC);
        t = (rl + 1) * ratio(code);
        wait_pulse(t + 10, k);
        if (code >= 6)
          check(k - 1 == t, "R7 timeout code>=6", 32'(k - 1), 32'(t));
        else
          check(k - 1 == t, "R6 timeout", 32'(k - 1), 32'(t));
      end
    end

    // R6 more reload values
    for (int i = 0; i < 3; i++) begin
      int rl;
      rl = (i == 0) ? 1 : (i == 1) ? 5 : 31;
      do_reset();
      setup(1, rl);
      wr(4'h0, 32'hCCCC);
      t = (rl + 1) * 8;
      wait_pulse(t + 10, k);
      check(k - 1 == t, "R6 timeout reload sweep", 32'(k - 1), 32'(t));
    end

    // R9 periodic, single-cycle, unstoppable
    do_reset();
    setup(0, 4);
    wr(4'h0, 32'hCCCC);
    wr(4'h0, 32'h0000);
    wr(4'h0, 32'h5555);
    wr(4'h0, 32'h1234);
    t = 20;
    wait_pulse(t + 10, k);
    check(k + 2 == t, "R9 pulse despite other keys", 32'(k + 2), 32'(t));
    @(negedge clk);
    check(rst_req == 1'b0, "R9 pulse one cycle", 32'(rst_req), 0);
    wait_pulse(t + 10, k);
    check(k + 1 == t, "R9 period", 32'(k + 1), 32'(t));

    // R8 kick restarts timeout
    do_reset();
    setup(0, 9);
    wr(4'h0, 32'hCCCC);
    seen = 0;
    repeat (30) begin @(negedge clk); if (rst_req) seen = 1; end
    #1;
    check(!seen, "R8 no pulse before kick", 32'(seen), 0);
    wr(4'h0, 32'hAAAA);
    wait_pulse(100, k);
    check(k - 1 == 40, "R8 timeout from kick", 32'(k - 1), 40);

    finish_test();
  end
endmodule